// File: doc/BRIEF.md
# Hardware Cursor Overlay Pixel Generator

This block turns a stream of raster positions into display colours for a framebuffer controller. Each cycle it may accept one pixel: its column, its row and the 8-bit colour index already fetched from video memory for that position. The index is translated to 24-bit RGB through a 256-entry colour lookup table held in an external register bank. A 64x64 hardware pointer is then laid on top. The pointer shape uses two bits per pixel, stored eight pixels to a 16-bit word, with eight words per pointer row. The shape and a three-entry pointer colour table are also read through ports of the register bank.

Two control inputs change the result. One hides the pointer everywhere. The other forces every pixel to black. The block is a two-stage pipeline. Stage one performs the lookups and the pointer area test, and stage two selects the colour. The coordinates and the valid flag travel with the data, so each result comes out exactly two clock edges after its input.

Top module: `curovl_pixgen`

## Requirements
- R1: A pixel accepted with `in_valid` high at clock edge n appears with `out_valid` high after edge n+1, together with the same `out_x` and `out_y`. `out_valid` is low after edge n+1 when `in_valid` was low at edge n.
- R2: A pixel outside the pointer area gets the colour table entry addressed by `in_index`. The block drives `pal_raddr` equal to `in_index` in the same cycle.
- R3: A pixel lies in the pointer area when 0 <= x-cx < 64 and 0 <= y-cy < 64. The differences are taken as signed values one bit wider than the coordinates, so a pointer near the far edge clips correctly and nothing wraps around.
- R4: Inside the area, the shape word address on `pat_raddr` is (y-cy)*8 + (x-cx)/8. The 2-bit code sits at bits [2s+1:2s] of that word, where s = (x-cx) mod 8.
- R5: Code 0 is transparent and shows the colour table entry. Codes 1, 2 and 3 show pointer colour entries 0, 1 and 2, which are read through `cpal_raddr`.
- R6: When `cursor_off` is high, the output is the colour table entry at every position.
- R7: When `blank_all` is high, the output colour is 24'h000000 regardless of the pointer.
- R8: `cursor_pos[23:12]` is the pointer column cx and `cursor_pos[11:0]` is the pointer row cy.
- R9: While reset is asserted, `out_valid` is low and `out_rgb` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Pixel present on the inputs |
| in_x | input | 12 | Pixel column |
| in_y | input | 12 | Pixel row |
| in_index | input | 8 | Colour index from video memory |
| cursor_pos | input | 24 | Pointer column (upper 12 bits) and row (lower 12 bits) |
| cursor_off | input | 1 | Hide the pointer |
| blank_all | input | 1 | Force black output |
| pal_raddr | output | 8 | Colour table read address |
| pal_rdata | input | 24 | Colour table entry, combinational |
| pat_raddr | output | 9 | Pointer shape word address |
| pat_rdata | input | 16 | Pointer shape word, combinational |
| cpal_raddr | output | 2 | Pointer colour table address (0..2) |
| cpal_rdata | input | 24 | Pointer colour entry, combinational |
| out_valid | output | 1 | Output pixel present |
| out_x | output | 12 | Output pixel column |
| out_y | output | 12 | Output pixel row |
| out_rgb | output | 24 | Output colour {R,G,B} |

## Verification
The assertions assume the three read ports answer combinationally in the same cycle as their address. They also assume `in_valid`, the coordinates and both control inputs hold known values from reset onward, because the checks compare outputs with input values two edges earlier. The bench models the register bank as combinational functions of the addresses, drives every input to a defined value from time zero, and changes inputs only on falling edges. Its pointer positions and coordinates include the area edges on all four sides, the clip at the maximum coordinate, and a large negative difference that would wrap if computed unsigned.

// File: rtl/curovl_pkg.sv
package curovl_pkg;
  localparam int CODE_W = 2;

  typedef enum logic [CODE_W-1:0] {
    CODE_CLEAR = 2'd0,
    CODE_COL0  = 2'd1,
    CODE_COL1  = 2'd2,
    CODE_COL2  = 2'd3
  } cur_code_e;
endpackage

// File: rtl/curovl_hit.sv
module curovl_hit #(
  parameter int COORD_W      = 12,
  parameter int CUR_SIZE     = 64,
  parameter int PIX_PER_WORD = 8,
  parameter int SLOT_W       = 3,
  parameter int WIDX_W       = 9
) (
  input  logic [COORD_W-1:0] x,
  input  logic [COORD_W-1:0] y,
  input  logic [COORD_W-1:0] cx,
  input  logic [COORD_W-1:0] cy,
  input  logic               cursor_off,
  output logic               hit,
  output logic [WIDX_W-1:0]  widx,
  output logic [SLOT_W-1:0]  slot
);
  localparam int DIFF_W = COORD_W + 1;
  localparam int CUR_LG = $clog2(CUR_SIZE);

  logic signed [DIFF_W-1:0] dx;
  logic signed [DIFF_W-1:0] dy;
  logic                     in_col;
  logic                     in_row;

  always_comb begin
    dx     = $signed({1'b0, x}) - $signed({1'b0, cx});
    dy     = $signed({1'b0, y}) - $signed({1'b0, cy});
    in_col = !dx[DIFF_W-1] && (dx < $signed(DIFF_W'(CUR_SIZE)));
    in_row = !dy[DIFF_W-1] && (dy < $signed(DIFF_W'(CUR_SIZE)));
    hit    = in_col && in_row && !cursor_off;
    widx   = WIDX_W'({dy[CUR_LG-1:0], dx[CUR_LG-1:SLOT_W]});
    slot   = dx[SLOT_W-1:0];
  end
endmodule

// File: rtl/curovl_s1.sv
module curovl_s1 #(
  parameter int COORD_W = 12,
  parameter int RGB_W   = 24,
  parameter int WORD_W  = 16,
  parameter int SLOT_W  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [COORD_W-1:0] in_x,
  input  logic [COORD_W-1:0] in_y,
  input  logic [RGB_W-1:0]   base_rgb,
  input  logic [WORD_W-1:0]  pat_word,
  input  logic [SLOT_W-1:0]  slot,
  input  logic               hit,
  input  logic               blank,
  output logic               s1_valid,
  output logic [COORD_W-1:0] s1_x,
  output logic [COORD_W-1:0] s1_y,
  output logic [RGB_W-1:0]   s1_rgb,
  output logic [WORD_W-1:0]  s1_word,
  output logic [SLOT_W-1:0]  s1_slot,
  output logic               s1_hit,
  output logic               s1_blank
);
  logic               valid_d;
  logic [COORD_W-1:0] x_d;
  logic [COORD_W-1:0] y_d;
  logic [RGB_W-1:0]   rgb_d;
  logic [WORD_W-1:0]  word_d;
  logic [SLOT_W-1:0]  slot_d;
  logic               hit_d;
  logic               blank_d;

  always_comb begin
    valid_d = in_valid;
    x_d     = s1_x;
    y_d     = s1_y;
    rgb_d   = s1_rgb;
    word_d  = s1_word;
    slot_d  = s1_slot;
    hit_d   = s1_hit;
    blank_d = s1_blank;
    if (in_valid) begin
      x_d     = in_x;
      y_d     = in_y;
      rgb_d   = base_rgb;
      word_d  = pat_word;
      slot_d  = slot;
      hit_d   = hit;
      blank_d = blank;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_x     <= '0;
      s1_y     <= '0;
      s1_rgb   <= '0;
      s1_word  <= '0;
      s1_slot  <= '0;
      s1_hit   <= 1'b0;
      s1_blank <= 1'b0;
    end else begin
      s1_valid <= valid_d;
      s1_x     <= x_d;
      s1_y     <= y_d;
      s1_rgb   <= rgb_d;
      s1_word  <= word_d;
      s1_slot  <= slot_d;
      s1_hit   <= hit_d;
      s1_blank <= blank_d;
    end
  end
endmodule

// File: rtl/curovl_s2.sv
module curovl_s2
  import curovl_pkg::*;
#(
  parameter int COORD_W      = 12,
  parameter int RGB_W        = 24,
  parameter int WORD_W       = 16,
  parameter int PIX_PER_WORD = 8,
  parameter int SLOT_W       = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               s1_valid,
  input  logic [COORD_W-1:0] s1_x,
  input  logic [COORD_W-1:0] s1_y,
  input  logic [RGB_W-1:0]   s1_rgb,
  input  logic [WORD_W-1:0]  s1_word,
  input  logic [SLOT_W-1:0]  s1_slot,
  input  logic               s1_hit,
  input  logic               s1_blank,
  output logic [1:0]         cpal_raddr,
  input  logic [RGB_W-1:0]   cpal_rdata,
  output logic               out_valid,
  output logic [COORD_W-1:0] out_x,
  output logic [COORD_W-1:0] out_y,
  output logic [RGB_W-1:0]   out_rgb
);
  logic [CODE_W-1:0]  codes [PIX_PER_WORD];
  cur_code_e          code;
  logic [COORD_W-1:0] x_d;
  logic [COORD_W-1:0] y_d;
  logic [RGB_W-1:0]   rgb_d;

  for (genvar s = 0; s < PIX_PER_WORD; s++) begin : g_slot
    assign codes[s] = s1_word[s*CODE_W +: CODE_W];
  end

  always_comb begin
    code       = cur_code_e'(codes[s1_slot]);
    cpal_raddr = (code == CODE_CLEAR) ? 2'd0 : 2'(code - 2'd1);
    x_d        = out_x;
    y_d        = out_y;
    rgb_d      = out_rgb;
    if (s1_valid) begin
      x_d = s1_x;
      y_d = s1_y;
      if (s1_blank)
        rgb_d = '0;
      else if (s1_hit && code != CODE_CLEAR)
        rgb_d = cpal_rdata;
      else
        rgb_d = s1_rgb;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_x     <= '0;
      out_y     <= '0;
      out_rgb   <= '0;
    end else begin
      out_valid <= s1_valid;
      out_x     <= x_d;
      out_y     <= y_d;
      out_rgb   <= rgb_d;
    end
  end
endmodule

// File: rtl/curovl_pixgen.sv
module curovl_pixgen #(
  parameter int COORD_W      = 12,
  parameter int IDX_W        = 8,
  parameter int COMP_W       = 8,
  parameter int CUR_SIZE     = 64,
  parameter int PIX_PER_WORD = 8,
  parameter int WORD_W       = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [COORD_W-1:0]   in_x,
  input  logic [COORD_W-1:0]   in_y,
  input  logic [IDX_W-1:0]     in_index,
  input  logic [2*COORD_W-1:0] cursor_pos,
  input  logic                 cursor_off,
  input  logic                 blank_all,
  output logic [IDX_W-1:0]     pal_raddr,
  input  logic [3*COMP_W-1:0]  pal_rdata,
  output logic [2*$clog2(CUR_SIZE)-$clog2(PIX_PER_WORD)-1:0] pat_raddr,
  input  logic [WORD_W-1:0]    pat_rdata,
  output logic [1:0]           cpal_raddr,
  input  logic [3*COMP_W-1:0]  cpal_rdata,
  output logic                 out_valid,
  output logic [COORD_W-1:0]   out_x,
  output logic [COORD_W-1:0]   out_y,
  output logic [3*COMP_W-1:0]  out_rgb
);
  localparam int RGB_W  = 3 * COMP_W;
  localparam int SLOT_W = $clog2(PIX_PER_WORD);
  localparam int WIDX_W = 2 * $clog2(CUR_SIZE) - SLOT_W;

  logic [COORD_W-1:0] cx;
  logic [COORD_W-1:0] cy;
  logic               hit;
  logic [SLOT_W-1:0]  slot;
  logic               s1_valid;
  logic [COORD_W-1:0] s1_x;
  logic [COORD_W-1:0] s1_y;
  logic [RGB_W-1:0]   s1_rgb;
  logic [WORD_W-1:0]  s1_word;
  logic [SLOT_W-1:0]  s1_slot;
  logic               s1_hit;
  logic               s1_blank;

  assign cx        = cursor_pos[2*COORD_W-1:COORD_W];
  assign cy        = cursor_pos[COORD_W-1:0];
  assign pal_raddr = in_index;

  curovl_hit #(
    .COORD_W(COORD_W), .CUR_SIZE(CUR_SIZE), .PIX_PER_WORD(PIX_PER_WORD),
    .SLOT_W(SLOT_W), .WIDX_W(WIDX_W)
  ) u_hit (
    .x(in_x), .y(in_y), .cx(cx), .cy(cy), .cursor_off(cursor_off),
    .hit(hit), .widx(pat_raddr), .slot(slot)
  );

  curovl_s1 #(
    .COORD_W(COORD_W), .RGB_W(RGB_W), .WORD_W(WORD_W), .SLOT_W(SLOT_W)
  ) u_s1 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_x(in_x), .in_y(in_y),
    .base_rgb(pal_rdata), .pat_word(pat_rdata), .slot(slot), .hit(hit),
    .blank(blank_all),
    .s1_valid(s1_valid), .s1_x(s1_x), .s1_y(s1_y), .s1_rgb(s1_rgb),
    .s1_word(s1_word), .s1_slot(s1_slot), .s1_hit(s1_hit), .s1_blank(s1_blank)
  );

  curovl_s2 #(
    .COORD_W(COORD_W), .RGB_W(RGB_W), .WORD_W(WORD_W),
    .PIX_PER_WORD(PIX_PER_WORD), .SLOT_W(SLOT_W)
  ) u_s2 (
    .clk(clk), .rst_n(rst_n), .s1_valid(s1_valid), .s1_x(s1_x), .s1_y(s1_y),
    .s1_rgb(s1_rgb), .s1_word(s1_word), .s1_slot(s1_slot), .s1_hit(s1_hit),
    .s1_blank(s1_blank), .cpal_raddr(cpal_raddr), .cpal_rdata(cpal_rdata),
    .out_valid(out_valid), .out_x(out_x), .out_y(out_y), .out_rgb(out_rgb)
  );
endmodule

// File: rtl/curovl_pixgen_chk.sv
module curovl_pixgen_chk #(
  parameter int COORD_W = 12,
  parameter int RGB_W   = 24
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic [COORD_W-1:0] in_x,
  input logic [COORD_W-1:0] in_y,
  input logic               cursor_off,
  input logic               blank_all,
  input logic [RGB_W-1:0]   pal_rdata,
  input logic               out_valid,
  input logic [COORD_W-1:0] out_x,
  input logic [COORD_W-1:0] out_y,
  input logic [RGB_W-1:0]   out_rgb
);
  logic [1:0] warm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      warm <= 2'd0;
    else if (warm != 2'd2)
      warm <= warm + 2'd1;
  end

  p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd2) |-> (out_valid == $past(in_valid, 2)));

  p_coord_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd2 && out_valid) |-> (out_x == $past(in_x, 2) && out_y == $past(in_y, 2)));

  p_blank_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd2 && out_valid && $past(blank_all, 2)) |-> (out_rgb == '0));

  p_hidden_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd2 && out_valid && $past(cursor_off, 2) && !$past(blank_all, 2))
      |-> (out_rgb == $past(pal_rdata, 2)));
endmodule

bind curovl_pixgen curovl_pixgen_chk #(.COORD_W(COORD_W), .RGB_W(3*COMP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_x(in_x), .in_y(in_y),
  .cursor_off(cursor_off), .blank_all(blank_all), .pal_rdata(pal_rdata),
  .out_valid(out_valid), .out_x(out_x), .out_y(out_y), .out_rgb(out_rgb)
);

// File: tb/curovl_pixgen_bench.sv
module curovl_pixgen_bench;
  localparam int NV = 11;
  localparam int VW = 58;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [11:0] in_x = '0;
  logic [11:0] in_y = '0;
  logic [7:0]  in_index = '0;
  logic [23:0] cursor_pos = '0;
  logic        cursor_off = 1'b0;
  logic        blank_all = 1'b0;
  logic [7:0]  pal_raddr;
  logic [23:0] pal_rdata;
  logic [8:0]  pat_raddr;
  logic [15:0] pat_rdata;
  logic [1:0]  cpal_raddr;
  logic [23:0] cpal_rdata;
  logic        out_valid;
  logic [11:0] out_x;
  logic [11:0] out_y;
  logic [23:0] out_rgb;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  function automatic logic [23:0] pal_fn(logic [7:0] i);
    return {i, ~i, i ^ 8'h5A};
  endfunction
  function automatic logic [15:0] pat_fn(logic [8:0] w);
    return 16'hE4E4 ^ {7'd0, w};
  endfunction
  function automatic logic [23:0] cpal_fn(logic [1:0] i);
    case (i)
      2'd0: return 24'hFF0000;
      2'd1: return 24'h00FF00;
      2'd2: return 24'h0000FF;
      default: return 24'h000000;
    endcase
  endfunction

  assign pal_rdata  = pal_fn(pal_raddr);
  assign pat_rdata  = pat_fn(pat_raddr);
  assign cpal_rdata = cpal_fn(cpal_raddr);

  curovl_pixgen u_curovl_pixgen (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_x(in_x), .in_y(in_y),
    .in_index(in_index), .cursor_pos(cursor_pos), .cursor_off(cursor_off),
    .blank_all(blank_all), .pal_raddr(pal_raddr), .pal_rdata(pal_rdata),
    .pat_raddr(pat_raddr), .pat_rdata(pat_rdata), .cpal_raddr(cpal_raddr),
    .cpal_rdata(cpal_rdata), .out_valid(out_valid), .out_x(out_x),
    .out_y(out_y), .out_rgb(out_rgb)
  );

  // Reference from the requirements (R3, R4, R5, R6, R7, R8)
  function automatic logic [23:0] model(int x, int y, logic [7:0] idx,
                                        logic [23:0] pos, bit cd, bit fb);
    int cx = int'(pos[23:12]);
    int cy = int'(pos[11:0]);
    int dx = x - cx;
    int dy = y - cy;
    logic [15:0] w;
    logic [1:0]  code;
    if (fb) return 24'h0;
    if (!cd && dx >= 0 && dx < 64 && dy >= 0 && dy < 64) begin
      w    = pat_fn(9'(dy * 8 + dx / 8));
      code = 2'((w >> ((dx % 8) * 2)) & 16'h3);
      if (code != 2'd0) return cpal_fn(code - 2'd1);
    end
    return pal_fn(idx);
  endfunction

  // {x, y, index, pos, cursor_off, blank_all}
  localparam logic [VW-1:0] VEC [NV] = '{
    {12'd100,  12'd50,   8'd3,  12'd100,  12'd50,   1'b0, 1'b0},
    {12'd101,  12'd50,   8'd3,  12'd100,  12'd50,   1'b0, 1'b0},
    {12'd99,   12'd50,   8'd7,  12'd100,  12'd50,   1'b0, 1'b0},
    {12'd163,  12'd113,  8'd9,  12'd100,  12'd50,   1'b0, 1'b0},
    {12'd164,  12'd113,  8'd9,  12'd100,  12'd50,   1'b0, 1'b0},
    {12'd120,  12'd114,  8'd11, 12'd100,  12'd50,   1'b0, 1'b0},
    {12'd120,  12'd49,   8'd12, 12'd100,  12'd50,   1'b0, 1'b0},
    {12'd4095, 12'd4001, 8'd20, 12'd4090, 12'd4000, 1'b0, 1'b0},
    {12'd101,  12'd50,   8'd33, 12'd100,  12'd50,   1'b1, 1'b0},
    {12'd101,  12'd50,   8'd33, 12'd100,  12'd50,   1'b0, 1'b1},
    {12'd0,    12'd0,    8'd44, 12'd4095, 12'd4095, 1'b0, 1'b0}
  };

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(int x, int y, logic [7:0] idx, logic [23:0] pos, bit cd, bit fb);
    in_valid   = 1'b1;
    in_x       = 12'(x);
    in_y       = 12'(y);
    in_index   = idx;
    cursor_pos = pos;
    cursor_off = cd;
    blank_all  = fb;
  endtask

  task automatic run_pix(int x, int y, logic [7:0] idx, logic [23:0] pos,
                         bit cd, bit fb, logic [23:0] exp, string req);
    @(negedge clk);
    drive(x, y, idx, pos, cd, fb);
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    check(out_valid && out_x == 12'(x) && out_y == 12'(y), "R1 valid/coords",
          {out_valid, 7'd0, out_x, out_y[11:0]}, {1'b1, 7'd0, 12'(x), 12'(y)});
    check(out_rgb == exp, req, 32'(out_rgb), 32'(exp));
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    check(out_valid == 1'b0 && out_rgb == 24'h0, "R9 reset",
          {7'd0, out_valid, out_rgb}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk, expected from the requirement model (R2..R8)
    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      run_pix(int'(v[57:46]), int'(v[45:34]), v[33:26], v[25:2], v[1], v[0],
              model(int'(v[57:46]), int'(v[45:34]), v[33:26], v[25:2], v[1], v[0]),
              "R3/R5 table");
    end

    // R5: hand-derived code colours (word 0 = E4E4: slots 0..3 give codes 0..3)
    run_pix(102, 50, 8'd5, {12'd100, 12'd50}, 1'b0, 1'b0, 24'h00FF00, "R5 code2");
    run_pix(103, 50, 8'd5, {12'd100, 12'd50}, 1'b0, 1'b0, 24'h0000FF, "R5 code3");
    run_pix(100, 50, 8'd5, {12'd100, 12'd50}, 1'b0, 1'b0, pal_fn(8'd5), "R5 code0 transparent");
    // R2: outside area uses colour table
    run_pix(10, 10, 8'd200, {12'd100, 12'd50}, 1'b0, 1'b0, pal_fn(8'd200), "R2 outside");
    // R6: pointer hidden on a code-3 pixel
    run_pix(103, 50, 8'd6, {12'd100, 12'd50}, 1'b1, 1'b0, pal_fn(8'd6), "R6 hidden");
    // R7: blank overrides pointer colour
    run_pix(103, 50, 8'd6, {12'd100, 12'd50}, 1'b0, 1'b1, 24'h0, "R7 blank");
    // R8: swapped fields put the pointer elsewhere
    run_pix(101, 50, 8'd8, {12'd50, 12'd100}, 1'b0, 1'b0, pal_fn(8'd8), "R8 field order");
    // R3: clip near maximum coordinate, code1 at dx=5, dy=1
    run_pix(4095, 4001, 8'd1, {12'd4090, 12'd4000}, 1'b0, 1'b0, 24'hFF0000, "R3 clip");

    // R4 / R2: read addresses in the input cycle
    @(negedge clk);
    drive(109, 52, 8'd77, {12'd100, 12'd50}, 1'b0, 1'b0);
    in_valid = 1'b0;
    #1;
    check(pat_raddr == 9'd17, "R4 word address", 32'(pat_raddr), 32'd17);
    check(pal_raddr == 8'd77, "R2 index address", 32'(pal_raddr), 32'd77);

    // R1: back-to-back pixels and valid drop
    @(negedge clk);
    drive(101, 50, 8'd2, {12'd100, 12'd50}, 1'b0, 1'b0);
    @(negedge clk);
    drive(300, 60, 8'd4, {12'd100, 12'd50}, 1'b0, 1'b0);
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid && out_x == 12'd101 && out_rgb == 24'hFF0000, "R1 stream first",
          32'(out_rgb), 32'hFF0000);
    @(negedge clk);
    check(out_valid && out_x == 12'd300 && out_rgb == pal_fn(8'd4), "R1 stream second",
          32'(out_rgb), 32'(pal_fn(8'd4)));
    @(negedge clk);
    check(out_valid == 1'b0, "R1 valid drop", 32'(out_valid), 32'd0);

    // R9: reset asserted mid-run
    drive(101, 50, 8'd2, {12'd100, 12'd50}, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(out_valid == 1'b0 && out_rgb == 24'h0, "R9 reset mid-run",
          {7'd0, out_valid, out_rgb}, 32'h0);
    in_valid = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule